// File: doc/BRIEF.md
# Smart-Card Half-Duplex Serial Transceiver

This block moves bytes over a single open-drain style line shared with a card or a card reader. Each character on the line is a low start bit, eight data bits, an even-parity bit and a guard interval in which the line is left released. A receiver that finds bad parity may pull the line low during that guard interval, and the sending side looks at the line in the middle of the guard interval to learn whether its character was refused. Two character conventions are supported. In direct convention data goes out low bit first at true levels. In inverse convention data goes out high bit first with every data and parity level inverted.

Bytes to send enter on a valid/ready stream. Received bytes leave on a one-entry valid/ready stream. A byte on either stream moves only in a cycle where valid and ready are both high. On the receive side `rx_valid` stays high and `rx_data` stays fixed until the consumer takes the byte. Back-pressure on that side never stalls the line. A byte that completes while the slot is still full is discarded, unless the consumer takes the old byte in the same cycle. All bit timing comes from `os_tick`, a one-cycle enable at sixteen times the bit rate. `pad_in` is taken to be synchronous to `clk` already. The pad is modelled as a level `pad_out` plus an enable `pad_oe`. When the enable is low, something outside the block holds the line high.

Top module: `sc_uart`

## Requirements
- R1: A transmitted character holds each of its ten driven bits (start, eight data, parity) for 16 `os_tick` periods. The start bit is low in both conventions.
- R2: With `cfg_inverse`=0, data bit k (k=0 first) drives level D[k] and the parity bit drives the XOR of all eight data bits (even parity).
- R3: With `cfg_inverse`=1, the data slots carry D7 first down to D0 with each level inverted, and the parity slot carries the inverted XOR of the data.
- R4: `pad_oe` is low whenever the block is idle and during the transmit guard interval; the block never drives the line high outside the ten transmitted bits.
- R5: The transmitter samples the line 8 ticks into the guard interval. A low there sets `tx_err`, and `tx_err` returns to 0 when the next byte is accepted.
- R6: `tx_done_irq` is a one-cycle pulse. It comes 176 ticks after acceptance with `cfg_errsig_en`=0 and 184 ticks (half a bit later) with `cfg_errsig_en`=1.
- R7: The receiver starts on the first tick that sees the line low. After 8 ticks it drops the attempt if the line is high. Otherwise it samples every following bit at 16-tick spacing, which places each sample at mid-bit.
- R8: `rx_done_irq` pulses for one cycle right after the parity sample, 152 ticks after the start detection. `rx_parity_err` then shows whether that character failed even parity, with parity taken over the logical byte.
- R9: On a parity failure with `cfg_errsig_en`=1, the block drives the line low (`pad_oe`=1, `pad_out`=0) for 16 ticks starting 8 ticks after the parity sample, then releases it. A good character, or a bad one with the enable at 0, never drives the line.
- R10: `rx_valid`/`rx_data` hold steady until taken. A byte completing while the slot is full and not being taken is dropped. If the take falls in the same cycle as the arrival, the new byte replaces the old one.
- R11: `tx_ready` is high only while both transmitter and receiver are idle; a byte is accepted on `tx_valid && tx_ready`.
- R12: While the transmitter is busy the receiver ignores the line, so the block's own character never produces a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Enable at 16x the bit rate |
| cfg_inverse | input | 1 | 1 selects inverse convention |
| cfg_errsig_en | input | 1 | 1 enables the error pulse and the delayed transmit completion |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte to send is present |
| tx_ready | output | 1 | Block can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is present |
| rx_ready | input | 1 | Consumer takes the received byte |
| pad_in | input | 1 | Line level seen at the pad |
| pad_out | output | 1 | Level driven when enabled |
| pad_oe | output | 1 | Pad drive enable; 0 releases the line |
| tx_err | output | 1 | Partner signalled a parity failure |
| tx_done_irq | output | 1 | Transmit-complete pulse |
| rx_parity_err | output | 1 | Last character failed parity |
| rx_done_irq | output | 1 | Receive-complete pulse |

## Verification
The arrival of a new received byte and the consumer taking the held byte can land on the same clock edge. The bench first runs one character with the slot empty and `rx_ready` low, and measures from `rx_done_irq` the exact cycle in which the slot loads. It then sends a second character with the same tick alignment and raises `rx_ready` for that single cycle only. It passes when the slot holds the second byte and is still valid. A third character sent with `rx_ready` low must then be dropped, leaving the second byte in place.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_FRAME,
    TX_GUARD,
    TX_EXTRA
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_ERRWAIT,
    RX_ERRDRV,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
  import sc_uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          cfg_inverse,
  input  logic          cfg_errsig_en,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          line_in,
  output logic          busy,
  output logic          drive_en,
  output logic          drive_val,
  output logic          err,
  output logic          done
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] PAR_IDX = BW'(DW + 1);

  tx_state_e     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic [DW-1:0] line_word;
  logic          par_line;
  logic          par_q;

  // Line image of the byte: bit 0 goes out first.
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      line_word[i] = cfg_inverse ? ~load_data[DW-1-i] : load_data[i];
    end
    par_line = cfg_inverse ? ~(^load_data) : (^load_data);
  end

  assign busy     = (state != TX_IDLE);
  assign drive_en = (state == TX_FRAME);
  assign drive_val = (bidx == '0)     ? 1'b0 :
                     (bidx == PAR_IDX) ? par_q : shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      par_q <= 1'b0;
      err   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        TX_IDLE: begin
          if (load) begin
            shreg <= line_word;
            par_q <= par_line;
            bidx  <= '0;
            cnt   <= '0;
            err   <= 1'b0;
            state <= TX_FRAME;
          end
        end
        TX_FRAME: begin
          if (os_tick) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (bidx == PAR_IDX) begin
                state <= TX_GUARD;
              end else begin
                if (bidx != '0) shreg <= shreg >> 1;
                bidx <= bidx + BW'(1);
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        TX_GUARD: begin
          if (os_tick) begin
            if (cnt == MID && !line_in) err <= 1'b1;
            if (cnt == LAST) begin
              cnt <= '0;
              if (cfg_errsig_en) begin
                state <= TX_EXTRA;
              end else begin
                done  <= 1'b1;
                state <= TX_IDLE;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        TX_EXTRA: begin
          if (os_tick) begin
            if (cnt == MID) begin
              done  <= 1'b1;
              state <= TX_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          cfg_inverse,
  input  logic          cfg_errsig_en,
  input  logic          listen,
  input  logic          line_in,
  output logic          idle,
  output logic          drive_low,
  output logic          done,
  output logic [DW-1:0] byte_out,
  output logic          parity_bad
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] PAR_IDX = BW'(DW);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          bad_now;

  // Even parity over the logical byte plus the logical parity bit.
  assign bad_now   = (^shreg) ^ (cfg_inverse ? ~line_in : line_in);
  assign idle      = (state == RX_IDLE);
  assign drive_low = (state == RX_ERRDRV);
  assign byte_out  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      done       <= 1'b0;
      parity_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (listen && os_tick && !line_in) begin
            cnt   <= '0;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (os_tick) begin
            if (cnt == MID) begin
              cnt   <= '0;
              bidx  <= '0;
              state <= line_in ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        RX_BITS: begin
          if (os_tick) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (bidx == PAR_IDX) begin
                done       <= 1'b1;
                parity_bad <= bad_now;
                state      <= (bad_now && cfg_errsig_en) ? RX_ERRWAIT : RX_STOP;
              end else begin
                shreg <= cfg_inverse ? {shreg[DW-2:0], ~line_in}
                                     : {line_in, shreg[DW-1:1]};
                bidx  <= bidx + BW'(1);
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        RX_ERRWAIT: begin
          if (os_tick) begin
            if (cnt == MID) begin
              cnt   <= '0;
              state <= RX_ERRDRV;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        RX_ERRDRV, RX_STOP: begin
          if (os_tick) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              state <= RX_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_uart_rx_slot.sv
module sc_uart_rx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          cfg_inverse,
  input  logic          cfg_errsig_en,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic          pad_in,
  output logic          pad_out,
  output logic          pad_oe,
  output logic          tx_err,
  output logic          tx_done_irq,
  output logic          rx_parity_err,
  output logic          rx_done_irq
);
  logic          tx_busy;
  logic          tx_drive;
  logic          tx_level;
  logic          rx_idle;
  logic          rx_drive_low;
  logic [DW-1:0] rx_byte;

  assign tx_ready = !tx_busy && rx_idle;

  sc_uart_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .cfg_inverse  (cfg_inverse),
    .cfg_errsig_en(cfg_errsig_en),
    .load         (tx_valid && tx_ready),
    .load_data    (tx_data),
    .line_in      (pad_in),
    .busy         (tx_busy),
    .drive_en     (tx_drive),
    .drive_val    (tx_level),
    .err          (tx_err),
    .done         (tx_done_irq)
  );

  sc_uart_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .cfg_inverse  (cfg_inverse),
    .cfg_errsig_en(cfg_errsig_en),
    .listen       (!tx_busy),
    .line_in      (pad_in),
    .idle         (rx_idle),
    .drive_low    (rx_drive_low),
    .done         (rx_done_irq),
    .byte_out     (rx_byte),
    .parity_bad   (rx_parity_err)
  );

  sc_uart_rx_slot #(.DW(DW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_done_irq),
    .in_data  (rx_byte),
    .out_valid(rx_valid),
    .out_data (rx_data),
    .out_ready(rx_ready)
  );

  assign pad_oe  = tx_drive | rx_drive_low;
  assign pad_out = tx_drive ? tx_level : 1'b0;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_errsig_en,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_busy,
  input logic          tx_err,
  input logic          tx_done_irq,
  input logic          rx_done_irq,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          pad_oe,
  input logic          pad_out
);
  // R4: whenever a new byte could be accepted the line is released
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !pad_oe);

  // R5: acceptance of a byte clears the error flag
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_err);

  // R6: transmit completion is a single-cycle pulse
  p_tx_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_irq |=> !tx_done_irq);

  // R8: receive completion is a single-cycle pulse
  p_rx_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |=> !rx_done_irq);

  // R9: drive outside a transmission is always low and only when enabled
  p_err_drive_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && !tx_busy) |-> (!pad_out && cfg_errsig_en));

  // R10: a held byte stays put until it is taken
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11: an accepted byte makes the block busy on the next cycle
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind sc_uart sc_uart_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_errsig_en(cfg_errsig_en),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_busy      (tx_busy),
  .tx_err       (tx_err),
  .tx_done_irq  (tx_done_irq),
  .rx_done_irq  (rx_done_irq),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_data      (rx_data),
  .pad_oe       (pad_oe),
  .pad_out      (pad_out)
);

// File: tb/sim_sc_uart.sv
module sim_sc_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 32;  // clocks per bit: 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       cfg_inverse = 1'b0;
  logic       cfg_errsig_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       pad_in;
  logic       pad_out;
  logic       pad_oe;
  logic       tx_err;
  logic       tx_done_irq;
  logic       rx_parity_err;
  logic       rx_done_irq;
  logic       drv_en = 1'b0;
  logic       drv_val = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tx_done_cnt = 0;
  int tx_done_cyc = 0;
  int rx_done_cnt = 0;
  int rx_done_cyc = 0;
  int oe_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Released line is pulled high; the partner may drive it.
  assign pad_in = pad_oe ? pad_out : (drv_en ? drv_val : 1'b1);

  always @(posedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= ~os_tick;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_done_irq) begin
      tx_done_cnt <= tx_done_cnt + 1;
      tx_done_cyc <= cyc;
    end
    if (rx_done_irq) begin
      rx_done_cnt <= rx_done_cnt + 1;
      rx_done_cyc <= cyc;
    end
    if (pad_oe) oe_cnt <= oe_cnt + 1;
  end

  sc_uart u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .cfg_inverse  (cfg_inverse),
    .cfg_errsig_en(cfg_errsig_en),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .tx_err       (tx_err),
    .tx_done_irq  (tx_done_irq),
    .rx_parity_err(rx_parity_err),
    .rx_done_irq  (rx_done_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [7:0] d, input logic inv, input int j);
    if (j == 0) return 1'b0;
    if (j <= 8) return inv ? ~d[8-j] : d[j-1];
    return inv ? ~(^d) : (^d);
  endfunction

  task automatic align_tick();
    @(negedge clk);
    while (!os_tick) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_ready == 1'b1, "R11", "tx_ready after reset", int'(tx_ready), 1);
    chk(pad_oe == 1'b0, "R4", "pad_oe after reset", int'(pad_oe), 0);
    chk(rx_valid == 1'b0, "R10", "rx_valid after reset", int'(rx_valid), 0);
    chk(tx_err == 1'b0, "R5", "tx_err after reset", int'(tx_err), 0);
  endtask

  // Send one byte, check every line bit at mid-bit, the guard release,
  // the completion delay, the error flag and the deaf receiver.
  task automatic t_tx_frame(input logic [7:0] d, input logic inv, input logic en,
                            input logic inject);
    int a;
    int dc0;
    int rc0;
    int expd;
    int delta;
    cfg_inverse   = inv;
    cfg_errsig_en = en;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R11", "tx_ready before send", int'(tx_ready), 1);
    tx_data  = d;
    tx_valid = 1'b1;
    dc0 = tx_done_cnt;
    rc0 = rx_done_cnt;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    a = cyc;
    chk(tx_err == 1'b0, "R5", "tx_err cleared by accept", int'(tx_err), 0);
    chk(tx_ready == 1'b0, "R11", "tx_ready while sending", int'(tx_ready), 0);
    for (int j = 0; j < 10; j++) begin
      wait_to(a + 16 + BITC * j);
      chk(pad_oe == 1'b1, (j == 0) ? "R1" : (inv ? "R3" : "R2"), "pad_oe in bit",
          int'(pad_oe), 1);
      chk(pad_out == exp_bit(d, inv, j), (j == 0) ? "R1" : (inv ? "R3" : "R2"),
          $sformatf("line bit %0d", j), int'(pad_out), int'(exp_bit(d, inv, j)));
    end
    wait_to(a + 320);
    if (inject) begin
      drv_en  = 1'b1;
      drv_val = 1'b0;
    end
    wait_to(a + 336);
    chk(pad_oe == 1'b0, "R4", "released in guard interval", int'(pad_oe), 0);
    wait_to(a + 352);
    drv_en  = 1'b0;
    drv_val = 1'b1;
    while (tx_done_cnt == dc0 && cyc < a + 600) @(negedge clk);
    expd  = en ? 368 : 352;
    delta = tx_done_cyc - a;
    chk(tx_done_cnt == dc0 + 1, "R6", "one completion pulse", tx_done_cnt - dc0, 1);
    chk(delta >= expd - 2 && delta <= expd + 2, "R6", "completion delay in clocks",
        delta, expd);
    chk(tx_err == inject, "R5", "tx_err after guard sample", int'(tx_err), int'(inject));
    chk(rx_done_cnt == rc0 && !rx_valid, "R12", "no reception of own character",
        rx_done_cnt - rc0, 0);
    repeat (8) @(negedge clk);
  endtask

  // Drive one character from the partner side; optional one-cycle take at poke.
  task automatic drive_frame(input logic [7:0] d, input logic inv, input logic corrupt,
                             input int poke, output int s);
    align_tick();
    s = cyc;
    drv_en = 1'b1;
    for (int j = 0; j < 10; j++) begin
      drv_val = exp_bit(d, inv, j) ^ (corrupt && j == 9);
      if (j == 3) begin
        wait_to(s + 100);
        chk(tx_ready == 1'b0, "R11", "tx_ready during reception", int'(tx_ready), 0);
      end
      if (j == 9 && poke > 0) begin
        wait_to(s + poke);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
      wait_to(s + BITC * (j + 1));
    end
    drv_en  = 1'b0;
    drv_val = 1'b1;
  endtask

  task automatic t_rx_frame(input logic [7:0] d, input logic inv, input logic en,
                            input logic corrupt);
    int s;
    int rc0;
    int oc0;
    cfg_inverse   = inv;
    cfg_errsig_en = en;
    rc0 = rx_done_cnt;
    oc0 = oe_cnt;
    drive_frame(d, inv, corrupt, 0, s);
    if (corrupt && en) begin
      wait_to(s + 336);
      chk(pad_oe == 1'b1 && pad_out == 1'b0, "R9", "error pulse drives low",
          int'(pad_oe), 1);
      wait_to(s + 368);
      chk(pad_oe == 1'b0, "R9", "error pulse released", int'(pad_oe), 0);
    end else begin
      wait_to(s + 368);
      chk(oe_cnt == oc0, "R9", "line never driven", oe_cnt - oc0, 0);
    end
    chk(rx_done_cnt == rc0 + 1, "R8", "one receive pulse", rx_done_cnt - rc0, 1);
    chk(rx_done_cyc - s == 305, "R7", "parity sampled at mid-bit (cycles)",
        rx_done_cyc - s, 305);
    chk(rx_parity_err == corrupt, "R8", "parity flag", int'(rx_parity_err), int'(corrupt));
    chk(rx_valid == 1'b1 && rx_data == d, inv ? "R3" : "R2", "received byte",
        int'(rx_data), int'(d));
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R10", "slot empties after take", int'(rx_valid), 0);
  endtask

  task automatic t_false_start();
    int s;
    int rc0;
    cfg_inverse   = 1'b0;
    cfg_errsig_en = 1'b1;
    rc0 = rx_done_cnt;
    align_tick();
    s = cyc;
    drv_en  = 1'b1;
    drv_val = 1'b0;
    wait_to(s + 6);
    drv_en  = 1'b0;
    drv_val = 1'b1;
    wait_to(s + 420);
    chk(rx_done_cnt == rc0, "R7", "short low pulse rejected", rx_done_cnt - rc0, 0);
    chk(rx_valid == 1'b0, "R7", "no byte from glitch", int'(rx_valid), 0);
  endtask

  task automatic t_take_and_arrive();
    int s;
    int d_cyc;
    cfg_inverse   = 1'b0;
    cfg_errsig_en = 1'b0;
    rx_ready      = 1'b0;
    drive_frame(8'h4E, 1'b0, 1'b0, 0, s);
    wait_to(s + 368);
    d_cyc = rx_done_cyc - s;
    chk(rx_valid == 1'b1 && rx_data == 8'h4E, "R10", "first byte held", int'(rx_data), 8'h4E);
    // Take the held byte on the edge where the next one lands in the slot.
    drive_frame(8'hB3, 1'b0, 1'b0, d_cyc, s);
    wait_to(s + 368);
    chk(rx_valid == 1'b1, "R10", "slot valid after coincident take", int'(rx_valid), 1);
    chk(rx_data == 8'hB3, "R10", "coincident take loads new byte", int'(rx_data), 8'hB3);
    drive_frame(8'h17, 1'b0, 1'b0, 0, s);
    wait_to(s + 368);
    chk(rx_valid == 1'b1 && rx_data == 8'hB3, "R10", "byte dropped while full",
        int'(rx_data), 8'hB3);
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R10", "only one byte held", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_frame(8'hA5, 1'b0, 1'b0, 1'b0);
    t_tx_frame(8'h3B, 1'b1, 1'b1, 1'b0);
    t_tx_frame(8'h5C, 1'b0, 1'b1, 1'b1);
    t_tx_frame(8'h00, 1'b0, 1'b0, 1'b0);
    t_rx_frame(8'h96, 1'b0, 1'b1, 1'b0);
    t_rx_frame(8'h2D, 1'b1, 1'b1, 1'b0);
    t_rx_frame(8'h71, 1'b0, 1'b1, 1'b1);
    t_rx_frame(8'hC4, 1'b1, 1'b1, 1'b1);
    t_rx_frame(8'hE8, 1'b0, 1'b0, 1'b1);
    t_false_start();
    t_take_and_arrive();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule